// File: doc/BRIEF.md
# Framed Serial Packet Transmitter

This block turns one packet into a continuous serial bit stream for a radio transceiver that adds no line coding of its own. The host first fills a payload buffer of up to 100 bytes through a byte-write port. It then presents an address byte and a payload length, and pulses `start`. The block emits the frame as one unbroken stream: an alternating-bit training pattern, a fixed start-of-frame marker, the address, the payload, and a 16-bit CRC that covers the marker, the address and the payload.

Bit timing comes from a divider on the system clock. Every bit is held for `CLK_DIV` clock cycles. `busy` stays high for the whole frame, and a one-cycle `done` pulse marks the end of the frame. A length outside 1..100 is refused with a one-cycle `len_err` pulse, and no frame is sent.

Top module: `pkt_serializer`

## Requirements
- R1: After reset, `ser_out`, `busy`, `done` and `len_err` are all 0.
- R2: A frame is `PRE_BYTES` bytes of 8'hAA, then `SOF_BYTE` (default 8'hD5), then `node_id`, then `pay_len` payload bytes from buffer entries 0 upward, then two CRC bytes. Each byte is sent MSB first.
- R3: Every bit of the frame stays on `ser_out` for exactly `CLK_DIV` clock cycles.
- R4: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, with no reflection and no final XOR. It covers the start-of-frame byte, the address and the payload, and its high byte is sent first.
- R5: A `start` with `pay_len` equal to 0 or above 100 gives `len_err` high for exactly the cycle after `start`. `busy` stays low and `ser_out` stays 0.
- R6: `busy` rises in the cycle after an accepted `start` and stays high until the last CRC bit has been held for its full period. In the following cycle `busy` is 0, `done` is 1 for one cycle, and `ser_out` is 0.
- R7: `ser_out` is 0 whenever `busy` is 0.
- R8: Buffer writes while `busy` is high are ignored, so the frame in flight carries the payload that was present at `start`.
- R9: A `start` while `busy` is high is ignored: the frame in flight continues unchanged and `len_err` stays low.
- R10: A payload of the maximum 100 bytes is sent in full with a correct CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Payload buffer write strobe |
| wr_addr | input | 7 | Payload buffer index (0..99) |
| wr_data | input | 8 | Payload byte to write |
| node_id | input | 8 | Address byte, sampled at start |
| pay_len | input | 7 | Payload length, sampled at start |
| start | input | 1 | Begin a frame (one-cycle pulse) |
| ser_out | output | 1 | Serial bit stream |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| len_err | output | 1 | One-cycle pulse for a rejected length |

## Verification
The assertions assume that `start` is a one-cycle pulse. They also assume that `CLK_DIV` is at least 2, so a bit period has a first cycle and a last cycle that can be told apart. The stimulus drives `start` high for one clock only and sets `CLK_DIV` to 4. It writes buffer entries only below 100. The writes and the extra `start` that it issues during a frame are there to test that the block ignores them.

// File: rtl/pkt_serializer.sv
module pkt_serializer #(
  parameter int CLK_DIV   = 100,
  parameter int PRE_BYTES = 2,
  parameter int MAX_LEN   = 100,
  parameter logic [7:0] SOF_BYTE = 8'hD5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [6:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] node_id,
  input  logic [6:0] pay_len,
  input  logic       start,
  output logic       ser_out,
  output logic       busy,
  output logic       done,
  output logic       len_err
);
  localparam int DW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);
  localparam logic [6:0] SOF_IDX = 7'(PRE_BYTES);
  localparam logic [6:0] ID_IDX  = 7'(PRE_BYTES + 1);
  localparam logic [6:0] PAY_IDX = 7'(PRE_BYTES + 2);

  logic [7:0]    buf_mem [MAX_LEN];
  logic [DW-1:0] div_cnt;
  logic [2:0]    bit_idx;
  logic [6:0]    byte_idx, len_q;
  logic [7:0]    id_q, cur_byte;
  logic [15:0]   crc;

  wire [6:0] crc_idx  = PAY_IDX + len_q;
  wire [6:0] last_idx = crc_idx + 7'd1;
  wire [6:0] pay_sel  = byte_idx - PAY_IDX;
  wire       tick     = busy && (div_cnt == DIV_LAST);
  wire       in_crc   = (byte_idx >= SOF_IDX) && (byte_idx < crc_idx);
  wire       len_ok   = (pay_len != 7'd0) && (int'(pay_len) <= MAX_LEN);

  always_comb begin
    if (byte_idx < SOF_IDX)       cur_byte = 8'hAA;
    else if (byte_idx == SOF_IDX) cur_byte = SOF_BYTE;
    else if (byte_idx == ID_IDX)  cur_byte = id_q;
    else if (byte_idx < crc_idx)  cur_byte = buf_mem[pay_sel];
    else if (byte_idx == crc_idx) cur_byte = crc[15:8];
    else                          cur_byte = crc[7:0];
  end

  assign ser_out = busy & cur_byte[3'd7 - bit_idx];

  always_ff @(posedge clk)
    if (wr_en && !busy && int'(wr_addr) < MAX_LEN)
      buf_mem[wr_addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; len_err <= 1'b0;
      div_cnt <= '0; bit_idx <= '0; byte_idx <= '0;
      len_q <= '0; id_q <= '0; crc <= 16'hFFFF;
    end else begin
      done    <= 1'b0;
      len_err <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (len_ok) begin
            busy <= 1'b1; len_q <= pay_len; id_q <= node_id;
            div_cnt <= '0; bit_idx <= '0; byte_idx <= '0; crc <= 16'hFFFF;
          end else begin
            len_err <= 1'b1;
          end
        end
      end else if (tick) begin
        div_cnt <= '0;
        if (in_crc)
          crc <= {crc[14:0], 1'b0} ^ ((crc[15] ^ ser_out) ? 16'h1021 : 16'h0000);
        bit_idx <= bit_idx + 3'd1;
        if (bit_idx == 3'd7) begin
          if (byte_idx == last_idx) begin
            busy <= 1'b0; done <= 1'b1; byte_idx <= '0;
          end else begin
            byte_idx <= byte_idx + 7'd1;
          end
        end
      end else begin
        div_cnt <= div_cnt + DW'(1);
      end
    end
  end

  // R7
  idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_out);
  // R6
  done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R5
  len_err_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> (!busy && !$past(busy) && $past(start)));
  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(div_cnt) != DIV_LAST) |-> $stable(ser_out));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/pkt_serializer_test.sv
module pkt_serializer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int PRE = 2;
  localparam logic [7:0] SOF = 8'hD5;
  localparam logic [22:0] VEC [0:3] = '{
    {7'd1,  8'h12, 8'h00},
    {7'd3,  8'h7E, 8'h33},
    {7'd12, 8'h01, 8'hA5},
    {7'd7,  8'hFF, 8'h5C}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, start = 0;
  logic [6:0] wr_addr = 0, pay_len = 0;
  logic [7:0] wr_data = 0, node_id = 0;
  logic ser_out, busy, done, len_err;
  int checks = 0, fails = 0;
  logic [7:0] expb [0:127];
  int n_exp;
  logic [7:0] got [0:127];
  int hold_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_serializer #(.CLK_DIV(DIV), .PRE_BYTES(PRE), .SOF_BYTE(SOF)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .node_id(node_id), .pay_len(pay_len), .start(start), .ser_out(ser_out),
    .busy(busy), .done(done), .len_err(len_err));

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(logic [7:0] seed, int i);
    return seed ^ 8'(i * 37);
  endfunction

  task automatic load(int len, logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); wr_en = 1; wr_addr = 7'(i); wr_data = pbyte(seed, i);
    end
    @(negedge clk); wr_en = 0;
  endtask

  task automatic build(int len, logic [7:0] id, logic [7:0] seed);
    logic [15:0] c = 16'hFFFF;
    int k = 0;
    for (int i = 0; i < PRE; i++) expb[k++] = 8'hAA;
    expb[k++] = SOF; expb[k++] = id;
    for (int i = 0; i < len; i++) expb[k++] = pbyte(seed, i);
    for (int j = PRE; j < k; j++)
      for (int b = 7; b >= 0; b--)
        c = {c[14:0], 1'b0} ^ ((c[15] ^ expb[j][b]) ? 16'h1021 : 16'h0000);
    expb[k++] = c[15:8]; expb[k++] = c[7:0];
    n_exp = k;
  endtask

  task automatic fire(int len, logic [7:0] id);
    @(negedge clk); pay_len = 7'(len); node_id = id; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic capture;
    logic a, b;
    hold_bad = 0;
    for (int k = 0; k < n_exp * 8; k++) begin
      if (k > 0) @(negedge clk);
      a = ser_out;
      if (!busy) hold_bad++;
      repeat (DIV - 1) @(negedge clk);
      b = ser_out;
      if (a !== b) hold_bad++;
      got[k/8][7 - (k%8)] = a;
    end
  endtask

  task automatic verify(string tag);
    for (int i = 0; i < n_exp; i++) chk(tag, got[i], expb[i]);
    chk("R3 hold", hold_bad, 0);
    @(negedge clk);
    chk("R6 done/busy/line", {done, busy, ser_out}, 3'b100);
    @(negedge clk);
    chk("R6 done single", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset", {ser_out, busy, done, len_err}, 4'b0000);
    rst_n = 1;
    @(negedge clk);
    chk("R7 idle line", ser_out, 0);

    // R2 R4: table-driven frames
    foreach (VEC[v]) begin
      load(int'(VEC[v][22:16]), VEC[v][7:0]);
      build(int'(VEC[v][22:16]), VEC[v][15:8], VEC[v][7:0]);
      fire(int'(VEC[v][22:16]), VEC[v][15:8]);
      chk("R6 busy rise", busy, 1);
      capture();
      verify("R2 R4 frame byte");
    end

    // R5 zero length
    fire(0, 8'h11);
    chk("R5 len 0", {len_err, busy, ser_out}, 3'b100);
    @(negedge clk);
    chk("R5 pulse end", {len_err, busy}, 2'b00);
    // R5 length 101
    fire(101, 8'h11);
    chk("R5 len 101", {len_err, busy, ser_out}, 3'b100);
    @(negedge clk);
    chk("R5 pulse end", {len_err, busy}, 2'b00);

    // R10 maximum payload
    load(100, 8'h3C);
    build(100, 8'h9A, 8'h3C);
    fire(100, 8'h9A);
    capture();
    verify("R10 max frame");

    // R8 R9: writes and start during a frame are ignored
    load(3, 8'h40);
    build(3, 8'h21, 8'h40);
    fire(3, 8'h21);
    fork
      capture();
      begin
        repeat (5) @(negedge clk);
        wr_en = 1; wr_addr = 0; wr_data = 8'hEE;
        @(negedge clk); wr_addr = 2; wr_data = 8'h00;
        @(negedge clk); wr_en = 0; pay_len = 7'd9; start = 1;
        @(negedge clk); start = 0;
        chk("R9 no len_err", len_err, 0);
        pay_len = 7'd0; start = 1;
        @(negedge clk); start = 0;
        chk("R9 bad len ignored", len_err, 0);
      end
    join
    verify("R8 R9 frame byte");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule